// File: doc/BRIEF.md
# Binary64 to Signed Integer Converter

This unit takes one IEEE-754 double-precision operand and produces a signed two's-complement integer. The result is either 32 bits wide, placed in the low half of a 64-bit result bus with the upper half zero, or a full 64-bit value. The fractional part is resolved by one of four rounding modes. Each operation normally uses a global mode. An operation whose source is a register may instead carry its own mode, which then replaces the global one.

The unit sets only two flags: invalid and inexact. Invalid covers NaN, either infinity, and any value whose rounded result does not fit the selected width. When invalid is masked, the result is the fixed integer-indefinite pattern, which has only the top bit of the chosen width set. When invalid is unmasked, the trap itself is handled elsewhere; this unit raises the flag and drives a zero result.

The conversion is combinational from the inputs to a single output register. A result therefore appears exactly one clock after its operand is presented with the valid strobe.

Top module: `fp2int_conv`

## Requirements
- R1: An operand accepted with `inValid` high gives `outValid` high together with its result and flags on the next clock. While `inValid` is low, `outValid` is low and the result and flags keep their last values. Reset clears all outputs to zero.
- R2: With `wideSel` = 1, an in-range value is returned as a 64-bit two's-complement integer.
- R3: With `wideSel` = 0, the result is a 32-bit two's-complement integer in bits 31:0, and bits 63:32 are zero.
- R4: Rounding-mode encoding: 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R5: The effective rounding mode is `overrideRm` when both `srcIsReg` and `rmOverride` are 1. Otherwise it is `globalRm`.
- R6: In 64-bit width, a rounded value outside [-2^63, 2^63-1] sets invalid. With `invalidMask` = 1, the result is 0x8000000000000000.
- R7: In 32-bit width, a rounded value outside [-2^31, 2^31-1] sets invalid. With `invalidMask` = 1, the result is 0x0000000080000000.
- R8: A NaN or infinite input (exponent field all ones) sets invalid and returns the indefinite value for the selected width. Inexact stays clear.
- R9: Inexact is set exactly when some discarded fraction bit is nonzero and the result is valid. Invalid and inexact are never both set.
- R10: Zero and subnormal inputs give 0, or +1 or -1 when directed rounding moves away from zero. A nonzero subnormal sets inexact. Negative zero gives 0.
- R11: The range check applies to the rounded value. In 32-bit width, -2^31-0.5 under nearest-even gives -2^31 and is valid. Under toward minus infinity it is invalid. 2^31-0.5 under nearest-even rounds to 2^31 and is invalid.
- R12: An invalid result with `invalidMask` = 0 drives a zero result and sets the invalid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand strobe |
| operand | input | 64 | Binary64 source value |
| wideSel | input | 1 | 1: 64-bit result, 0: 32-bit result |
| globalRm | input | 2 | Global rounding mode |
| rmOverride | input | 1 | Per-operation rounding override enable |
| overrideRm | input | 2 | Per-operation rounding mode |
| srcIsReg | input | 1 | Source is a register (override permitted) |
| invalidMask | input | 1 | 1: invalid masked, return indefinite |
| outValid | output | 1 | Result strobe |
| result | output | 64 | Integer result |
| invalidFlag | output | 1 | Invalid-operation flag |
| inexactFlag | output | 1 | Precision flag |

## Verification
The main conversion path is exercised with several groups of inputs:
- Exact integers of both signs, which show whether the alignment shift and the negation are correct.
- Values with exactly half or with quarter fractions, run under all four modes. These separate the tie-to-even rule from the directed rounding modes.
- Values right at the two width boundaries, before and after rounding. These show whether the range check is applied to the rounded value or to the truncated value.
- Zeros, subnormals, NaNs and infinities, which test the special-case classification.
- A random sweep with exponents clustered near the integer range, compared against an arithmetic model in the bench. This catches errors in the guard and sticky bits that the directed cases miss.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
  localparam int EXP_W     = 11;
  localparam int FRAC_W    = 52;
  localparam int MANT_W    = FRAC_W + 1;
  localparam int INT_W     = 64;
  localparam int NARROW_W  = 32;
  localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
  // biased exponent at which the mantissa is an exact integer
  localparam int POINT_EXP = BIAS + FRAC_W;
  // biased exponent at which magnitude reaches 2^INT_W
  localparam int BIG_EXP   = BIAS + INT_W;
  // right shift beyond which every mantissa bit lands below the guard bit
  localparam int SHIFT_CAP = MANT_W + 1;
  localparam int SH_W      = $clog2(SHIFT_CAP + 1);
  localparam int EXT_W     = MANT_W + INT_W;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_DOWN    = 2'b01,
    RM_UP      = 2'b10,
    RM_ZERO    = 2'b11
  } rm_e;

  typedef struct packed {
    logic             special;   // NaN or infinity
    logic             bigExp;    // magnitude at least 2^INT_W
    logic             useLeft;   // integer needs a left shift
    logic             hiddenOne; // implicit leading one
    logic [EXP_W-1:0] lshift;
    logic [SH_W-1:0]  rshift;
    rm_e              rm;
    logic             wide;
    logic             maskInv;
  } ctrl_t;
endpackage

// File: rtl/fp2int_ctrl.sv
module fp2int_ctrl
  import fp2int_pkg::*;
(
  input  logic [EXP_W-1:0] expField,
  input  logic             wideSel,
  input  logic [1:0]       globalRm,
  input  logic             rmOverride,
  input  logic [1:0]       overrideRm,
  input  logic             srcIsReg,
  input  logic             invalidMask,
  output ctrl_t            strobes
);
  localparam logic [EXP_W-1:0] EXP_ALL1  = '1;
  localparam logic [EXP_W-1:0] EXP_POINT = EXP_W'(POINT_EXP);
  localparam logic [EXP_W-1:0] EXP_BIG   = EXP_W'(BIG_EXP);
  localparam logic [EXP_W-1:0] EXP_CAP   = EXP_W'(SHIFT_CAP);

  logic [EXP_W-1:0] leftAmt;
  logic [EXP_W-1:0] rightAmt;
  logic             takeOverride;

  always_comb begin
    leftAmt      = expField - EXP_POINT;
    rightAmt     = EXP_POINT - expField;
    takeOverride = srcIsReg & rmOverride;

    strobes.special   = (expField == EXP_ALL1);
    strobes.bigExp    = (expField >= EXP_BIG) && (expField != EXP_ALL1);
    strobes.useLeft   = (expField >= EXP_POINT);
    strobes.hiddenOne = (expField != '0);
    strobes.lshift    = strobes.useLeft ? leftAmt : '0;

    if (strobes.useLeft || (expField == '0) || (rightAmt > EXP_CAP))
      strobes.rshift = SH_W'(SHIFT_CAP);
    else
      strobes.rshift = rightAmt[SH_W-1:0];

    strobes.rm      = rm_e'(takeOverride ? overrideRm : globalRm);
    strobes.wide    = wideSel;
    strobes.maskInv = invalidMask;
  end
endmodule

// File: rtl/fp2int_dp.sv
module fp2int_dp
  import fp2int_pkg::*;
(
  input  ctrl_t             strobes,
  input  logic              opSign,
  input  logic [FRAC_W-1:0] opFrac,
  output logic [INT_W-1:0]  res,
  output logic              invalid,
  output logic              inexact
);
  localparam logic [INT_W:0]   WIDE_NEG_LIM   = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W:0]   NARROW_NEG_LIM = {{(INT_W-NARROW_W+1){1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};
  localparam logic [INT_W-1:0] INDEF_WIDE     = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] INDEF_NARROW   = {{(INT_W-NARROW_W){1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};

  logic [MANT_W-1:0] mant;
  logic [EXT_W-1:0]  ext;
  logic [INT_W-1:0]  leftVal;
  logic [INT_W-1:0]  mag;
  logic              guardBit;
  logic              stickyBit;
  logic              roundUp;
  logic [INT_W:0]    sum;
  logic [INT_W-1:0]  signedVal;
  logic              outRange;

  // alignment
  always_comb begin
    mant    = {strobes.hiddenOne, opFrac};
    ext     = {mant, {INT_W{1'b0}}} >> strobes.rshift;
    leftVal = INT_W'(mant) << strobes.lshift;
    if (strobes.useLeft) begin
      mag       = leftVal;
      guardBit  = 1'b0;
      stickyBit = 1'b0;
    end else begin
      mag       = INT_W'(ext[EXT_W-1:INT_W]);
      guardBit  = ext[INT_W-1];
      stickyBit = |ext[INT_W-2:0];
    end
  end

  // rounding decision
  always_comb begin
    unique case (strobes.rm)
      RM_NEAREST: roundUp = guardBit & (stickyBit | mag[0]);
      RM_DOWN:    roundUp = opSign & (guardBit | stickyBit);
      RM_UP:      roundUp = ~opSign & (guardBit | stickyBit);
      default:    roundUp = 1'b0;
    endcase
    sum = {1'b0, mag} + (INT_W+1)'(roundUp);
  end

  // range check on the rounded magnitude, then result selection
  always_comb begin
    if (strobes.wide)
      outRange = opSign ? (sum > WIDE_NEG_LIM) : (sum[INT_W:INT_W-1] != '0);
    else
      outRange = opSign ? (sum > NARROW_NEG_LIM) : (sum[INT_W:NARROW_W-1] != '0);

    invalid   = strobes.special | strobes.bigExp | outRange;
    inexact   = (guardBit | stickyBit) & ~invalid;
    signedVal = opSign ? (-sum[INT_W-1:0]) : sum[INT_W-1:0];

    if (invalid)
      res = strobes.maskInv ? (strobes.wide ? INDEF_WIDE : INDEF_NARROW) : '0;
    else if (strobes.wide)
      res = signedVal;
    else
      res = {{(INT_W-NARROW_W){1'b0}}, signedVal[NARROW_W-1:0]};
  end
endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv
  import fp2int_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [63:0] operand,
  input  logic        wideSel,
  input  logic [1:0]  globalRm,
  input  logic        rmOverride,
  input  logic [1:0]  overrideRm,
  input  logic        srcIsReg,
  input  logic        invalidMask,
  output logic        outValid,
  output logic [63:0] result,
  output logic        invalidFlag,
  output logic        inexactFlag
);
  ctrl_t            strobes;
  logic [INT_W-1:0] dpRes;
  logic             dpInvalid;
  logic             dpInexact;

  fp2int_ctrl u_ctrl (
    .expField   (operand[FRAC_W +: EXP_W]),
    .wideSel    (wideSel),
    .globalRm   (globalRm),
    .rmOverride (rmOverride),
    .overrideRm (overrideRm),
    .srcIsReg   (srcIsReg),
    .invalidMask(invalidMask),
    .strobes    (strobes)
  );

  fp2int_dp u_dp (
    .strobes(strobes),
    .opSign (operand[FRAC_W+EXP_W]),
    .opFrac (operand[FRAC_W-1:0]),
    .res    (dpRes),
    .invalid(dpInvalid),
    .inexact(dpInexact)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      result      <= '0;
      invalidFlag <= 1'b0;
      inexactFlag <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result      <= dpRes;
        invalidFlag <= dpInvalid;
        inexactFlag <= dpInexact;
      end
    end
  end
endmodule

// File: rtl/fp2int_checker.sv
module fp2int_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [63:0] operand,
  input logic        wideSel,
  input logic        invalidMask,
  input logic        outValid,
  input logic [63:0] result,
  input logic        invalidFlag,
  input logic        inexactFlag
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result) && $stable(invalidFlag) && $stable(inexactFlag));
  a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(wideSel)) |-> (result[63:32] == 32'h0));
  a_r6_wide_indef: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && invalidFlag && $past(invalidMask) && $past(wideSel))
      |-> (result == 64'h8000_0000_0000_0000));
  a_r7_narrow_indef: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && invalidFlag && $past(invalidMask) && !$past(wideSel))
      |-> (result == 64'h0000_0000_8000_0000));
  a_r8_special_invalid: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (operand[62:52] == 11'h7FF)) |=> (invalidFlag && !inexactFlag));
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(invalidFlag && inexactFlag));
  a_r12_unmasked_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && invalidFlag && !$past(invalidMask)) |-> (result == 64'h0));
endmodule

bind fp2int_conv fp2int_checker u_fp2int_checker (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .operand    (operand),
  .wideSel    (wideSel),
  .invalidMask(invalidMask),
  .outValid   (outValid),
  .result     (result),
  .invalidFlag(invalidFlag),
  .inexactFlag(inexactFlag)
);

// File: tb/tb_fp2int_conv.sv
`timescale 1ns/1ps
module tb_fp2int_conv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] operand = '0;
  logic        wideSel = 1'b0;
  logic [1:0]  globalRm = 2'b00;
  logic        rmOverride = 1'b0;
  logic [1:0]  overrideRm = 2'b00;
  logic        srcIsReg = 1'b0;
  logic        invalidMask = 1'b1;
  logic        outValid;
  logic [63:0] result;
  logic        invalidFlag;
  logic        inexactFlag;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  logic [66:0] expQ[$];
  string       tagQ[$];
  logic [65:0] held = '0;

  always #2.5 clk = ~clk;

  fp2int_conv dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(operand),
    .wideSel(wideSel), .globalRm(globalRm), .rmOverride(rmOverride),
    .overrideRm(overrideRm), .srcIsReg(srcIsReg), .invalidMask(invalidMask),
    .outValid(outValid), .result(result), .invalidFlag(invalidFlag),
    .inexactFlag(inexactFlag)
  );

  // arithmetic reference: {invalid, inexact, result}
  function automatic logic [65:0] refConv(input logic [63:0] op, input logic w,
                                          input logic [1:0] rm, input logic msk);
    logic s, inv, incr, inx;
    int e, ex;
    logic [52:0]  mant;
    logic [255:0] q;
    logic [127:0] ip, fr, half, lim;
    logic [63:0]  v, res;
    s = op[63]; e = int'(op[62:52]); inv = 1'b0; ip = '0; fr = '0;
    if (e == 2047) inv = 1'b1;
    else begin
      mant = (e == 0) ? {1'b0, op[51:0]} : {1'b1, op[51:0]};
      ex   = (e == 0) ? -1074 : e - 1075;
      if (ex > 20) inv = 1'b1;
      else if (ex < -120) fr = (mant != 0) ? 128'd1 : 128'd0;
      else begin
        q  = 256'(mant) << (128 + ex);
        ip = q[255:128];
        fr = q[127:0];
      end
    end
    half = 128'd1 << 127;
    case (rm)
      2'b00:   incr = (fr > half) || ((fr == half) && ip[0]);
      2'b01:   incr = s && (fr != 0);
      2'b10:   incr = !s && (fr != 0);
      default: incr = 1'b0;
    endcase
    ip  = ip + 128'(incr);
    lim = w ? (128'd1 << 63) : (128'd1 << 31);
    if (!inv) inv = s ? (ip > lim) : (ip >= lim);
    v = s ? -ip[63:0] : ip[63:0];
    if (inv) res = msk ? (w ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000) : 64'h0;
    else     res = w ? v : {32'h0, v[31:0]};
    inx = (fr != 0) && !inv;
    return {inv, inx, res};
  endfunction

  task automatic compareFront();
    logic [66:0] e, a;
    string t;
    if (expQ.size() != 0) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = {outValid, invalidFlag, inexactFlag, result};
      nVec++;
      if (a !== e) begin
        nBad++;
        $display("FAIL %s: got vld=%0b inv=%0b inx=%0b res=%h, expected vld=%0b inv=%0b inx=%0b res=%h",
                 t, a[66], a[65], a[64], a[63:0], e[66], e[65], e[64], e[63:0]);
      end
    end
  endtask

  task automatic conv(input logic [63:0] op, input logic w, input logic [1:0] grm,
                      input logic ovr, input logic [1:0] orm, input logic isReg,
                      input logic msk, input string tag);
    logic [1:0] eff;
    @(negedge clk);
    compareFront();
    inValid = 1'b1; operand = op; wideSel = w; globalRm = grm;
    rmOverride = ovr; overrideRm = orm; srcIsReg = isReg; invalidMask = msk;
    eff  = (isReg && ovr) ? orm : grm;
    held = refConv(op, w, eff, msk);
    expQ.push_back({1'b1, held});
    tagQ.push_back(tag);
  endtask

  // plain conversion with the global mode and masked invalid
  task automatic cv(input real r, input logic w, input logic [1:0] rm, input string tag);
    conv($realtobits(r), w, rm, 1'b0, 2'b00, 1'b0, 1'b1, tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    compareFront();
    inValid = 1'b0;
    operand = 64'h7FF0_0000_0000_0000;
    expQ.push_back({1'b0, held});
    tagQ.push_back(tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL R1 watchdog: got hung run, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    nVec++;
    if ({outValid, invalidFlag, inexactFlag, result} !== 67'h0) begin
      nBad++;
      $display("FAIL R1 reset: got vld=%0b res=%h, expected 0", outValid, result);
    end
    rstN = 1'b1;

    // R2 wide exact values
    cv(123456789012.0, 1'b1, 2'b11, "R2 wide large positive");
    cv(-7.0, 1'b1, 2'b00, "R2 wide negative");
    cv(3.0, 1'b1, 2'b01, "R2 wide small");
    // R3 narrow
    cv(-7.0, 1'b0, 2'b00, "R3 narrow negative upper zero");
    cv(2147483647.0, 1'b0, 2'b00, "R3 narrow max");
    // R1 idle holds outputs
    idle("R1 idle hold");
    idle("R1 idle hold 2");
    // R4 each mode, ties and non-ties
    for (int m = 0; m < 4; m++) begin
      cv(2.5, 1'b1, 2'(m), "R4 +2.5");
      cv(-2.5, 1'b1, 2'(m), "R4 -2.5");
      cv(3.5, 1'b0, 2'(m), "R4 +3.5");
      cv(-2.75, 1'b0, 2'(m), "R4 -2.75");
      cv(2.25, 1'b1, 2'(m), "R4 +2.25");
    end
    // R5 override selection (global toward zero, override toward +inf)
    conv($realtobits(2.5), 1'b1, 2'b11, 1'b1, 2'b10, 1'b1, 1'b1, "R5 override taken");
    conv($realtobits(2.5), 1'b1, 2'b11, 1'b1, 2'b10, 1'b0, 1'b1, "R5 memory source ignores override");
    conv($realtobits(2.5), 1'b1, 2'b11, 1'b0, 2'b10, 1'b1, 1'b1, "R5 override disabled");
    // R6 wide range
    cv(9223372036854775808.0, 1'b1, 2'b00, "R6 wide 2^63 overflow");
    cv(-9223372036854775808.0, 1'b1, 2'b00, "R6 wide -2^63 valid");
    cv(1.0e30, 1'b1, 2'b11, "R6 wide huge");
    // R7 narrow range
    cv(2147483648.0, 1'b0, 2'b00, "R7 narrow 2^31 overflow");
    cv(-2147483648.0, 1'b0, 2'b00, "R7 narrow -2^31 valid");
    cv(-5.0e9, 1'b0, 2'b11, "R7 narrow negative overflow");
    // R8 specials
    conv(64'h7FF8_0000_0000_0000, 1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 1'b1, "R8 NaN wide");
    conv(64'hFFF0_0000_0000_0000, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b1, "R8 -inf narrow");
    conv(64'h7FF0_0000_0000_0000, 1'b1, 2'b10, 1'b0, 2'b00, 1'b0, 1'b1, "R8 +inf wide");
    // R9 inexact
    cv(0.75, 1'b1, 2'b11, "R9 inexact to zero");
    cv(1.0e20, 1'b1, 2'b00, "R9 overflow not inexact");
    // R10 zeros and subnormals
    cv(0.0, 1'b1, 2'b10, "R10 +0");
    conv(64'h8000_0000_0000_0000, 1'b1, 2'b01, 1'b0, 2'b00, 1'b0, 1'b1, "R10 -0");
    conv(64'h0000_0000_0000_0001, 1'b1, 2'b10, 1'b0, 2'b00, 1'b0, 1'b1, "R10 subnormal up");
    conv(64'h8000_0000_0000_0001, 1'b0, 2'b01, 1'b0, 2'b00, 1'b0, 1'b1, "R10 neg subnormal down");
    conv(64'h0000_0000_0000_0001, 1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 1'b1, "R10 subnormal nearest");
    cv(0.3, 1'b0, 2'b10, "R10 small up");
    cv(-0.3, 1'b1, 2'b01, "R10 small down");
    // R11 range after rounding
    cv(-2147483648.5, 1'b0, 2'b00, "R11 -2^31-0.5 nearest");
    cv(-2147483648.5, 1'b0, 2'b01, "R11 -2^31-0.5 down");
    cv(2147483647.5, 1'b0, 2'b00, "R11 2^31-0.5 nearest");
    cv(2147483647.5, 1'b0, 2'b11, "R11 2^31-0.5 toward zero");
    // R12 unmasked invalid
    conv($realtobits(2147483648.0), 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, "R12 narrow unmasked");
    conv(64'h7FF8_0000_0000_0001, 1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, "R12 NaN unmasked");

    // R2 random sweep near the integer range
    for (int i = 0; i < 400; i++) begin
      logic [63:0] op;
      logic [10:0] ex;
      int sel;
      sel = $urandom_range(0, 19);
      if (sel == 0)      ex = 11'h000;
      else if (sel == 1) ex = 11'h7FF;
      else               ex = 11'(990 + $urandom_range(0, 100));
      op = {1'($urandom), ex, 52'({$urandom(), $urandom()})};
      conv(op, 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom), "R2 random");
    end
    idle("R1 final idle");
    @(negedge clk);
    compareFront();

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule